// File: doc/BRIEF.md
# Dual-Accumulator Arithmetic Unit with Sticky Overflow

This block holds two signed accumulators (40 bits by default) and applies one operation to them per start strobe. The operations are: loading an accumulator from an input word, absolute value, rounding away the low word, a non-destructive compare of accumulator 0 against accumulator 1, and a test of one accumulator. Every operation except the load rewrites a status register. That register reports carry, overflow, zero, sign, a flag for results outside the signed 32-bit range, and a flag for equal top bits of the middle word.

An overflow sets both the ordinary overflow bit and a sticky overflow bit. A later flag update may clear the ordinary bit, but the sticky bit stays set until reset. A controller can therefore run a whole sequence of operations and then find out whether any step overflowed. Instruction decode, the multiplier and memory addressing belong to the surrounding core. That core drives the opcode, the accumulator select and the strobe.

Top module: `acc_alu_core`

## Requirements
- R1: After reset, both accumulators and every status bit are zero.
- R2: Opcode 0 (load) writes `load_data` into the accumulator chosen by `acc_sel` (0 or 1) and leaves the status register unchanged.
- R3: Opcode 1 (absolute value) replaces the selected accumulator with its negation only when bit 39 is set, and leaves it unchanged otherwise. Carry (bit 0) is cleared. Overflow (bit 1) is cleared, except when the input is the most negative value: that value wraps to itself and sets overflow.
- R4: Opcode 2 (round) adds 0x8000 to the selected accumulator modulo 2^40, then forces bits [15:0] to zero. Carry and overflow are cleared.
- R5: Opcode 3 (compare) forms acc0 − acc1 modulo 2^40 without writing either accumulator. Carry is set when acc0 ≥ that difference, both read as unsigned. Overflow is set when acc0 and the wrapped negation of acc1 share a sign and the difference has the other sign. The remaining flags come from the difference.
- R6: Opcode 4 (test) leaves the accumulators unchanged, clears carry and overflow, and sets the other flags from the selected accumulator.
- R7: Every flag update sets bit 2 when the 40-bit result is zero, bit 3 from result bit 39, and bit 4 when result bits [39:31] are not all equal. It sets bit 5 when result bits 31 and 30 are equal, and clears bit 6 (logic-zero) and bits [15:8].
- R8: Bit 7 (sticky overflow) is set on any operation that sets bit 1. It is never cleared except by reset.
- R9: Opcodes 5 to 7, and any cycle with `start` low, change neither accumulator nor the status register.
- R10: Results of an operation appear on the outputs right after the rising clock edge that samples `start` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Perform the operation this cycle |
| opcode | input | 3 | Operation code (0 load, 1 abs, 2 round, 3 compare, 4 test) |
| acc_sel | input | 1 | Accumulator operand/destination select |
| load_data | input | ACC_W | Value written by the load operation |
| acc0_q | output | ACC_W | Accumulator 0 |
| acc1_q | output | ACC_W | Accumulator 1 |
| status_q | output | 16 | Status register |

## Verification
Some properties are checked on every cycle. Overflow always implies the sticky bit, and the sticky bit never falls while reset is released. Idle cycles and compares leave the accumulators untouched. Rounding accumulator 0 always clears its low word, and an absolute value result is non-negative unless overflow is raised. Zero and sign never appear together.

Other behaviour only the directed scenarios can show, because it needs exact values. This covers the carry and overflow arithmetic of compare, including the case where acc1 is the most negative value. It also covers the rounding boundaries at 0x7FFF and 0x8000, the wrap of rounding at the positive limit, the 32-bit range and top-bits flags on both sides of their thresholds, and the sticky bit surviving later operations that clear overflow.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [2:0] {
      OP_LOAD = 3'd0,
      OP_ABS  = 3'd1,
      OP_RND  = 3'd2,
      OP_CMP  = 3'd3,
      OP_TST  = 3'd4
   } alu_op_e;

   localparam int unsigned STAT_W = 16;

   // Low byte of the status register, bit 0 at the right.
   typedef struct packed {
      logic sticky;   // bit 7
      logic lzero;    // bit 6
      logic top2;     // bit 5
      logic over32;   // bit 4
      logic sign;     // bit 3
      logic zero;     // bit 2
      logic ovf;      // bit 1
      logic carry;    // bit 0
   } flag_bits_t;

endpackage

// File: rtl/acc_bank.sv
module acc_bank #(
   parameter int unsigned ACC_W   = 40,
   parameter int unsigned NUM_ACC = 2,
   localparam int unsigned SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic [ACC_W-1:0]     wr_data,
   output logic [ACC_W-1:0]     acc_q [NUM_ACC]
);

   generate
      for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_acc
         always_ff @(posedge clk) begin
            if (!rst_n)
               acc_q[gi] <= '0;
            else if (wr_en && (wr_sel == SEL_W'(gi)))
               acc_q[gi] <= wr_data;
         end
      end
   endgenerate

endmodule

// File: rtl/acc_op_unit.sv
module acc_op_unit
   import acc_alu_pkg::*;
#(
   parameter int unsigned ACC_W = 40,
   parameter int unsigned LOW_W = 16
) (
   input  logic              start,
   input  logic [2:0]        opcode,
   input  logic              acc_sel,
   input  logic [ACC_W-1:0]  load_data,
   input  logic [ACC_W-1:0]  acc0,
   input  logic [ACC_W-1:0]  acc1,
   output logic              wr_en,
   output logic [ACC_W-1:0]  wr_data,
   output logic              flag_en,
   output logic [ACC_W-1:0]  flag_val,
   output logic              carry,
   output logic              ovf
);

   localparam int unsigned MSB = ACC_W - 1;
   localparam logic [ACC_W-1:0] HALF_LSB = ACC_W'(1) << (LOW_W - 1);
   localparam logic [ACC_W-1:0] LOW_MASK = (ACC_W'(1) << LOW_W) - ACC_W'(1);
   localparam logic [ACC_W-1:0] MOST_NEG = ACC_W'(1) << MSB;

   logic [ACC_W-1:0] src;
   logic [ACC_W-1:0] src_neg;
   logic [ACC_W-1:0] abs_val;
   logic [ACC_W-1:0] rnd_val;
   logic [ACC_W-1:0] diff;
   logic [ACC_W-1:0] sub_neg;
   logic             cmp_carry;
   logic             cmp_ovf;
   alu_op_e          op;

   assign op        = alu_op_e'(opcode);
   assign src       = acc_sel ? acc1 : acc0;
   assign src_neg   = ~src + ACC_W'(1);
   assign abs_val   = src[MSB] ? src_neg : src;
   assign rnd_val   = (src + HALF_LSB) & ~LOW_MASK;
   assign diff      = acc0 - acc1;
   assign sub_neg   = ~acc1 + ACC_W'(1);
   assign cmp_carry = (acc0 >= diff);
   assign cmp_ovf   = (acc0[MSB] == sub_neg[MSB]) && (diff[MSB] != acc0[MSB]);

   always_comb begin
      wr_en    = 1'b0;
      wr_data  = src;
      flag_en  = 1'b0;
      flag_val = src;
      carry    = 1'b0;
      ovf      = 1'b0;
      if (start) begin
         case (op)
            OP_LOAD: begin
               wr_en   = 1'b1;
               wr_data = load_data;
            end
            OP_ABS: begin
               wr_en    = 1'b1;
               wr_data  = abs_val;
               flag_en  = 1'b1;
               flag_val = abs_val;
               ovf      = (src == MOST_NEG);
            end
            OP_RND: begin
               wr_en    = 1'b1;
               wr_data  = rnd_val;
               flag_en  = 1'b1;
               flag_val = rnd_val;
            end
            OP_CMP: begin
               flag_en  = 1'b1;
               flag_val = diff;
               carry    = cmp_carry;
               ovf      = cmp_ovf;
            end
            OP_TST: begin
               flag_en  = 1'b1;
               flag_val = src;
            end
            default: begin
               wr_en   = 1'b0;
               flag_en = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit
   import acc_alu_pkg::*;
#(
   parameter int unsigned ACC_W = 40,
   parameter int unsigned LOW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flag_en,
   input  logic [ACC_W-1:0]  flag_val,
   input  logic              carry,
   input  logic              ovf,
   output logic [STAT_W-1:0] status_q
);

   localparam int unsigned WORD2_TOP = 2 * LOW_W - 1;
   localparam int unsigned GUARD_W   = ACC_W - WORD2_TOP;

   flag_bits_t cur_fl;
   flag_bits_t nxt_fl;
   logic       beyond_32;

   generate
      if (GUARD_W > 1) begin : g_guard
         logic [GUARD_W-1:0] guard;
         assign guard     = flag_val[ACC_W-1:WORD2_TOP];
         assign beyond_32 = !((&guard) || (~|guard));
      end else begin : g_noguard
         assign beyond_32 = 1'b0;
      end
   endgenerate

   assign cur_fl = flag_bits_t'(status_q[7:0]);

   always_comb begin
      nxt_fl        = '0;
      nxt_fl.carry  = carry;
      nxt_fl.ovf    = ovf;
      nxt_fl.zero   = (flag_val == '0);
      nxt_fl.sign   = flag_val[ACC_W-1];
      nxt_fl.over32 = beyond_32;
      nxt_fl.top2   = (flag_val[WORD2_TOP] == flag_val[WORD2_TOP-1]);
      nxt_fl.lzero  = 1'b0;
      nxt_fl.sticky = cur_fl.sticky | ovf;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         status_q <= '0;
      else if (flag_en)
         status_q <= {{(STAT_W-8){1'b0}}, nxt_fl};
   end

endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
   import acc_alu_pkg::*;
#(
   parameter int unsigned ACC_W = 40,
   parameter int unsigned LOW_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        opcode,
   input  logic              acc_sel,
   input  logic [ACC_W-1:0]  load_data,
   output logic [ACC_W-1:0]  acc0_q,
   output logic [ACC_W-1:0]  acc1_q,
   output logic [15:0]       status_q
);

   localparam int unsigned NUM_ACC = 2;

   generate
      if (ACC_W < 2 * LOW_W) begin : g_bad_width
         $error("acc_alu_core: ACC_W must hold at least two low words");
      end
      if (LOW_W < 2) begin : g_bad_low
         $error("acc_alu_core: LOW_W must be at least 2");
      end
   endgenerate

   logic              wr_en;
   logic [ACC_W-1:0]  wr_data;
   logic              flag_en;
   logic [ACC_W-1:0]  flag_val;
   logic              carry;
   logic              ovf;
   logic [ACC_W-1:0]  acc_arr [NUM_ACC];

   acc_bank #(.ACC_W(ACC_W), .NUM_ACC(NUM_ACC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (acc_sel),
      .wr_data (wr_data),
      .acc_q   (acc_arr)
   );

   acc_op_unit #(.ACC_W(ACC_W), .LOW_W(LOW_W)) u_op (
      .start     (start),
      .opcode    (opcode),
      .acc_sel   (acc_sel),
      .load_data (load_data),
      .acc0      (acc_arr[0]),
      .acc1      (acc_arr[1]),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .flag_en   (flag_en),
      .flag_val  (flag_val),
      .carry     (carry),
      .ovf       (ovf)
   );

   acc_flag_unit #(.ACC_W(ACC_W), .LOW_W(LOW_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .flag_en  (flag_en),
      .flag_val (flag_val),
      .carry    (carry),
      .ovf      (ovf),
      .status_q (status_q)
   );

   assign acc0_q = acc_arr[0];
   assign acc1_q = acc_arr[1];

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
   parameter int unsigned ACC_W = 40,
   parameter int unsigned LOW_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [2:0]        opcode,
   input logic              acc_sel,
   input logic [ACC_W-1:0]  acc0_q,
   input logic [ACC_W-1:0]  acc1_q,
   input logic [15:0]       status_q
);

   p_ovf_sets_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[1] |-> status_q[7]);

   p_sticky_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      status_q[7] |=> status_q[7]);

   p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ($stable(acc0_q) && $stable(acc1_q) && $stable(status_q)));

   p_cmp_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && opcode == 3'd3) |=> ($stable(acc0_q) && $stable(acc1_q)));

   p_rnd_low_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && opcode == 3'd2 && !acc_sel) |=> (acc0_q[LOW_W-1:0] == '0));

   p_abs_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && opcode == 3'd1 && !acc_sel) |=> (!acc0_q[ACC_W-1] || status_q[1]));

   p_zero_sign_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(status_q[2] && status_q[3]));

endmodule

bind acc_alu_core acc_alu_chk #(.ACC_W(ACC_W), .LOW_W(LOW_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .opcode   (opcode),
   .acc_sel  (acc_sel),
   .acc0_q   (acc0_q),
   .acc1_q   (acc1_q),
   .status_q (status_q)
);

// File: tb/acc_alu_core_bench.sv
module acc_alu_core_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  opcode = 3'd0;
   logic        acc_sel = 1'b0;
   logic [39:0] load_data = '0;
   logic [39:0] acc0_q, acc1_q;
   logic [15:0] status_q;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   logic [39:0] m_acc [2];
   logic [15:0] m_stat;

   always #2.5 clk = ~clk;

   acc_alu_core u_acc_alu_core (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
      .acc_sel(acc_sel), .load_data(load_data),
      .acc0_q(acc0_q), .acc1_q(acc1_q), .status_q(status_q)
   );

   function automatic longint sx(logic [39:0] v);
      return longint'({{24{v[39]}}, v});
   endfunction

   // Flag word from a wrapped result, per R7/R8.
   function automatic logic [15:0] mk_stat(logic [39:0] r, logic c, logic v, logic [15:0] old);
      logic [15:0] s;
      longint rs;
      rs = sx(r);
      s = '0;
      s[0] = c;
      s[1] = v;
      s[2] = (rs == 0);
      s[3] = (rs < 0);
      s[4] = (rs > 64'sd2147483647) || (rs < -64'sd2147483648);
      s[5] = (r[31] == r[30]);
      s[7] = old[7] | v;
      return s;
   endfunction

   task automatic chk(string req, string what, logic [39:0] act, logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(string req);
      chk(req, "acc0", acc0_q, m_acc[0]);
      chk(req, "acc1", acc1_q, m_acc[1]);
      chk(req, "status", {24'd0, status_q}, {24'd0, m_stat});
   endtask

   // Issue one operation, update the model, check after the sampling edge (R10).
   task automatic run_op(string req, logic [2:0] op, logic sel, logic [39:0] data);
      logic [39:0] s, r, nb;
      logic [1:0] ixs;
      @(negedge clk);
      opcode = op; acc_sel = sel; load_data = data; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      ixs = {1'b0, sel};
      s = m_acc[ixs];
      case (op)
         3'd0: m_acc[ixs] = data;
         3'd1: begin
            r = (sx(s) < 0) ? 40'(-sx(s)) : s;
            m_acc[ixs] = r;
            m_stat = mk_stat(r, 1'b0, s == 40'h80_0000_0000, m_stat);
         end
         3'd2: begin
            r = 40'(s + 40'h8000) & ~40'hFFFF;
            m_acc[ixs] = r;
            m_stat = mk_stat(r, 1'b0, 1'b0, m_stat);
         end
         3'd3: begin
            r = 40'(m_acc[0] - m_acc[1]);
            nb = 40'(-sx(m_acc[1]));
            m_stat = mk_stat(r, m_acc[0] >= r,
                             (m_acc[0][39] == nb[39]) && (r[39] != m_acc[0][39]), m_stat);
         end
         3'd4: m_stat = mk_stat(s, 1'b0, 1'b0, m_stat);
         default: ;
      endcase
      chk_all(req);
   endtask

   task automatic t_reset;
      m_acc[0] = '0; m_acc[1] = '0; m_stat = '0;
      chk_all("R1");
   endtask

   task automatic t_load;
      run_op("R2", 3'd0, 1'b0, 40'h12_3456_789A);
      run_op("R2", 3'd0, 1'b1, 40'hF0_0000_0001);
   endtask

   task automatic t_test;
      run_op("R6", 3'd4, 1'b0, '0);      // positive, beyond 32-bit range
      run_op("R6", 3'd4, 1'b1, '0);      // negative
      run_op("R2", 3'd0, 1'b0, 40'h00_0000_0000);
      run_op("R7", 3'd4, 1'b0, '0);      // zero: bit2 set, bit5 set
      run_op("R2", 3'd0, 1'b0, 40'h00_7FFF_FFFF);
      run_op("R7", 3'd4, 1'b0, '0);      // top of 32-bit range, bits31/30 differ
      run_op("R2", 3'd0, 1'b0, 40'h00_8000_0000);
      run_op("R7", 3'd4, 1'b0, '0);      // just beyond 32-bit range
   endtask

   task automatic t_abs;
      run_op("R2", 3'd0, 1'b1, 40'hFF_FFFF_FF00);
      run_op("R3", 3'd1, 1'b1, '0);      // negative -> 0x100
      run_op("R3", 3'd1, 1'b1, '0);      // positive unchanged
      run_op("R2", 3'd0, 1'b0, 40'h80_0000_0000);
      run_op("R3", 3'd1, 1'b0, '0);      // most negative wraps, overflow + sticky
      chk("R3", "ovf bit", {39'd0, status_q[1]}, 40'd1);
   endtask

   task automatic t_sticky;
      run_op("R8", 3'd4, 1'b1, '0);      // clears overflow, sticky stays
      chk("R8", "sticky bit", {39'd0, status_q[7]}, 40'd1);
      chk("R8", "ovf bit", {39'd0, status_q[1]}, 40'd0);
   endtask

   task automatic t_round;
      run_op("R2", 3'd0, 1'b0, 40'h12_3456_8000);
      run_op("R4", 3'd2, 1'b0, '0);      // rounds up to ..5700_0000? (0x1234570000)
      chk("R4", "round up", acc0_q, 40'h12_3457_0000);
      run_op("R2", 3'd0, 1'b1, 40'hFF_FFFF_7FFF);
      run_op("R4", 3'd2, 1'b1, '0);      // rounds down
      chk("R4", "round down", acc1_q, 40'hFF_FFFF_0000);
      run_op("R2", 3'd0, 1'b0, 40'h7F_FFFF_FFFF);
      run_op("R4", 3'd2, 1'b0, '0);      // wraps to most negative
      chk("R4", "round wrap", acc0_q, 40'h80_0000_0000);
   endtask

   task automatic t_compare;
      run_op("R2", 3'd0, 1'b0, 40'h00_0000_0005);
      run_op("R2", 3'd0, 1'b1, 40'h00_0000_0005);
      run_op("R5", 3'd3, 1'b0, '0);      // equal
      run_op("R2", 3'd0, 1'b1, 40'h00_0000_0009);
      run_op("R5", 3'd3, 1'b0, '0);      // less
      run_op("R2", 3'd0, 1'b0, 40'h7F_0000_0000);
      run_op("R2", 3'd0, 1'b1, 40'hF0_0000_0000);
      run_op("R5", 3'd3, 1'b0, '0);      // signed overflow
      chk("R5", "cmp ovf", {39'd0, status_q[1]}, 40'd1);
      run_op("R2", 3'd0, 1'b0, 40'hFF_FFFF_FFFF);
      run_op("R2", 3'd0, 1'b1, 40'h80_0000_0000);
      run_op("R5", 3'd3, 1'b0, '0);      // acc1 most negative corner
   endtask

   task automatic t_ignored;
      run_op("R9", 3'd5, 1'b0, 40'h11_1111_1111);
      run_op("R9", 3'd7, 1'b1, 40'h22_2222_2222);
      @(negedge clk);
      opcode = 3'd0; acc_sel = 1'b0; load_data = 40'h33_3333_3333; start = 1'b0;
      @(negedge clk);
      chk_all("R9");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_load();
      t_test();
      t_abs();
      t_sticky();
      t_round();
      t_compare();
      t_ignored();
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule